// File: doc/BRIEF.md
# Priority I/O Crossbar Pin Allocator

This block decides which peripheral signal drives each of sixteen port pins. The pins sit on two 8-bit ports and are numbered 0 to 15. A fixed list of seventeen peripheral signals is walked from the highest priority to the lowest. The two UART signals go to fixed pins. Every other enabled signal takes the lowest-numbered pin that is still free and not reserved by software.

Software reserves pins through a 16-bit skip mask, which it writes one port byte at a time. A flag gives the SPI mode, so that the slave-select line asks for a pin only when the SPI runs in its four-wire form.

The allocation is built combinationally from the enables, the mode flag and the mask, and is registered once per clock. For each pin the outputs give a function code and an in-use flag. For each signal they give the pin it received and a flag that says it could not be placed.

Top module: `io_xbar_alloc`

## Requirements
- R1: Signal codes, which are also the bit positions in `sig_en_i`, set the priority, with 0 the highest. The codes are: 0 UART TX, 1 UART RX, 2 SPI clock, 3 SPI MISO, 4 SPI MOSI, 5 SPI slave select, 6 LIN TX, 7 LIN RX, 8 comparator out, 9 comparator async out, 10 system clock out, 11 to 13 capture/compare 0 to 2, 14 counter external clock, 15 timer 0 input, 16 timer 1 input.
- R2: Codes 2 to 16 are taken in ascending code order. Each enabled one receives the lowest pin index that is neither skipped nor already given out. `sig_pin_o[4k+3:4k]` reports the pin index of signal k.
- R3: UART TX (code 0), when enabled, always sits on pin 4, and UART RX (code 1) always sits on pin 5, whatever the skip mask holds. While enabled, each of them keeps its pin from every other signal.
- R4: Skip mask bit p covers pin p. Pins 0 to 7 are port 0 and pins 8 to 15 are port 1. A write with `skip_wr_sel_i`=0 loads bits 7:0 and a write with `skip_wr_sel_i`=1 loads bits 15:8. The mask resets to all zeros.
- R5: A pin whose skip bit is set never receives any of codes 2 to 16.
- R6: SPI slave select (code 5) is placed only while `spi_4wire_i`=1. Otherwise it takes no pin and is not flagged as unplaced, even when enabled.
- R7: A disabled signal takes no pin, reports pin index 0 and unplaced 0, and the signals after it move down to fill the gap.
- R8: An enabled signal that finds no free pin raises `sig_unplaced_o[k]`, reports pin index 0 and appears on no pin.
- R9: `pin_func_o[5p+4:5p]` holds the code of the signal on pin p, or 31 when the pin stays GPIO. `pin_used_o[p]` is 1 exactly when that code is not 31.
- R10: A change on `sig_en_i` or `spi_4wire_i` reaches the outputs at the next rising clock edge. A skip-mask write reaches the outputs at the second edge, because the mask is registered first.
- R11: While `rst` is high at a clock edge, every pin returns to code 31 and unused, every signal reports pin 0 and placed, and skip writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_en_i | input | 17 | Per-signal enables, indexed by code |
| spi_4wire_i | input | 1 | SPI runs in four-wire mode |
| skip_wr_en_i | input | 1 | Skip-mask byte write strobe |
| skip_wr_sel_i | input | 1 | Port byte chosen for the write |
| skip_wr_data_i | input | 8 | Skip bits for the chosen port |
| pin_func_o | output | 80 | Per-pin 5-bit function code |
| pin_used_o | output | 16 | Per-pin assigned flag |
| sig_pin_o | output | 68 | Per-signal 4-bit pin index |
| sig_unplaced_o | output | 17 | Per-signal not-placed flag |

## Verification
The hardest case to reach is running out of pins. With UART enabled only fourteen pins are left for fifteen searched signals, so exhaustion normally touches just the last enabled signal. Reaching the other cases needs the skip mask to block most pins first.

The stimulus therefore writes both mask bytes to near-full and full patterns and then sweeps enable sets across them. It also runs long stretches of random enables, random masks and random mode flags. The reference model places signals by popping a queue of free pins, and it is compared with every output on every clock.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NUM_SIG     = 17;
  localparam int CODE_W      = 5;
  localparam logic [CODE_W-1:0] CODE_GPIO = 5'd31;
  localparam int SIG_TX      = 0;
  localparam int SIG_RX      = 1;
  localparam int SIG_SEL     = 5;
  localparam int TX_PIN      = 4;
  localparam int RX_PIN      = 5;
endpackage

// File: rtl/xbar_skip_regs.sv
module xbar_skip_regs #(
  parameter int PORT_W    = 8,
  parameter int NUM_PORTS = 2,
  localparam int NUM_PIN  = PORT_W * NUM_PORTS,
  localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [PORT_W-1:0]  wr_data,
  output logic [NUM_PIN-1:0] skip_o
);
  logic [PORT_W-1:0] bank [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst)
        bank[p] <= '0;
      else if (wr_en && wr_sel == SEL_W'(p))
        bank[p] <= wr_data;
    end
    assign skip_o[p*PORT_W +: PORT_W] = bank[p];

    // R4: a write to one port byte leaves the other bytes alone
    a_r4_byte_isolated: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !($past(wr_en) && $past(wr_sel) == SEL_W'(p)))
        |-> $stable(bank[p]));
  end
endmodule

// File: rtl/xbar_lsb_pick.sv
module xbar_lsb_pick #(
  parameter int W  = 16,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [W-1:0]  onehot,
  output logic [IW-1:0] idx
);
  always_comb begin
    onehot = req & (~req + {{(W-1){1'b0}}, 1'b1});
    found  = |req;
    idx    = '0;
    for (int i = 0; i < W; i++)
      if (onehot[i]) idx = IW'(i);
  end
endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import xbar_pkg::*;
#(
  parameter int NUM_PIN = 16,
  localparam int PIN_W  = $clog2(NUM_PIN)
) (
  input  logic [NUM_SIG-1:0]        sig_en,
  input  logic                      spi_4wire,
  input  logic [NUM_PIN-1:0]        skip,
  output logic [NUM_PIN*CODE_W-1:0] pin_func,
  output logic [NUM_PIN-1:0]        pin_used,
  output logic [NUM_SIG*PIN_W-1:0]  sig_pin,
  output logic [NUM_SIG-1:0]        sig_unplaced
);
  logic [NUM_PIN-1:0] occ   [NUM_SIG+1];
  logic [NUM_PIN-1:0] grant [NUM_SIG];
  logic [NUM_PIN-1:0] fixed_res;

  assign fixed_res = (sig_en[SIG_TX] ? (NUM_PIN'(1) << TX_PIN) : '0)
                   | (sig_en[SIG_RX] ? (NUM_PIN'(1) << RX_PIN) : '0);
  assign occ[0] = skip | fixed_res;

  for (genvar k = 0; k < NUM_SIG; k++) begin : g_sig
    if (k == SIG_TX || k == SIG_RX) begin : g_fixed
      localparam int FIX = (k == SIG_TX) ? TX_PIN : RX_PIN;
      assign grant[k]        = sig_en[k] ? (NUM_PIN'(1) << FIX) : '0;
      assign sig_unplaced[k] = 1'b0;
      assign sig_pin[k*PIN_W +: PIN_W] = sig_en[k] ? PIN_W'(FIX) : '0;
      assign occ[k+1]        = occ[k];
    end else begin : g_search
      logic             active, found;
      logic [NUM_PIN-1:0] onehot;
      logic [PIN_W-1:0] idx;
      assign active = sig_en[k] && ((k != SIG_SEL) || spi_4wire);
      xbar_lsb_pick #(.W(NUM_PIN)) u_pick (
        .req    (~occ[k]),
        .found  (found),
        .onehot (onehot),
        .idx    (idx)
      );
      assign grant[k]        = (active && found) ? onehot : '0;
      assign sig_unplaced[k] = active && !found;
      assign sig_pin[k*PIN_W +: PIN_W] = (active && found) ? idx : '0;
      assign occ[k+1]        = occ[k] | grant[k];
    end
  end

  always_comb begin
    pin_used = '0;
    for (int k = 0; k < NUM_SIG; k++) pin_used |= grant[k];
  end

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    always_comb begin
      pin_func[p*CODE_W +: CODE_W] = CODE_GPIO;
      for (int k = 0; k < NUM_SIG; k++)
        if (grant[k][p]) pin_func[p*CODE_W +: CODE_W] = CODE_W'(k);
    end
  end
endmodule

// File: rtl/io_xbar_alloc.sv
module io_xbar_alloc
  import xbar_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int NUM_PORTS = 2,
  localparam int NUM_PIN  = PORT_W * NUM_PORTS,
  localparam int PIN_W    = $clog2(NUM_PIN),
  localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SIG-1:0]        sig_en_i,
  input  logic                      spi_4wire_i,
  input  logic                      skip_wr_en_i,
  input  logic [SEL_W-1:0]          skip_wr_sel_i,
  input  logic [PORT_W-1:0]         skip_wr_data_i,
  output logic [NUM_PIN*CODE_W-1:0] pin_func_o,
  output logic [NUM_PIN-1:0]        pin_used_o,
  output logic [NUM_SIG*PIN_W-1:0]  sig_pin_o,
  output logic [NUM_SIG-1:0]        sig_unplaced_o
);
  logic [NUM_PIN-1:0]        skip_q;
  logic [NUM_PIN*CODE_W-1:0] func_d;
  logic [NUM_PIN-1:0]        used_d;
  logic [NUM_SIG*PIN_W-1:0]  pin_d;
  logic [NUM_SIG-1:0]        unpl_d;

  xbar_skip_regs #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_skip (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (skip_wr_en_i),
    .wr_sel  (skip_wr_sel_i),
    .wr_data (skip_wr_data_i),
    .skip_o  (skip_q)
  );

  xbar_alloc #(.NUM_PIN(NUM_PIN)) u_alloc (
    .sig_en       (sig_en_i),
    .spi_4wire    (spi_4wire_i),
    .skip         (skip_q),
    .pin_func     (func_d),
    .pin_used     (used_d),
    .sig_pin      (pin_d),
    .sig_unplaced (unpl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_func_o     <= {NUM_PIN{CODE_GPIO}};
      pin_used_o     <= '0;
      sig_pin_o      <= '0;
      sig_unplaced_o <= '0;
    end else begin
      pin_func_o     <= func_d;
      pin_used_o     <= used_d;
      sig_pin_o      <= pin_d;
      sig_unplaced_o <= unpl_d;
    end
  end

  // Checks on the registered outputs
  logic [NUM_PIN-1:0] sel_hit;
  for (genvar p = 0; p < NUM_PIN; p++) begin : g_chk
    assign sel_hit[p] = (pin_func_o[p*CODE_W +: CODE_W] == CODE_W'(SIG_SEL));

    // R9: the in-use flag agrees with the function code
    a_r9_used_matches: assert property (@(posedge clk) disable iff (rst)
      pin_used_o[p] == (pin_func_o[p*CODE_W +: CODE_W] != CODE_GPIO));

    // R5: a skipped pin carries only GPIO or a fixed UART signal
    a_r5_skip_respected: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(skip_q[p]))
        |-> (pin_func_o[p*CODE_W +: CODE_W] == CODE_GPIO ||
             pin_func_o[p*CODE_W +: CODE_W] < CODE_W'(2)));
  end

  // R3: enabled UART TX lands on its fixed pin
  a_r3_tx_fixed: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sig_en_i[SIG_TX]))
      |-> pin_func_o[TX_PIN*CODE_W +: CODE_W] == CODE_W'(SIG_TX));

  // R3: enabled UART RX lands on its fixed pin
  a_r3_rx_fixed: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sig_en_i[SIG_RX]))
      |-> pin_func_o[RX_PIN*CODE_W +: CODE_W] == CODE_W'(SIG_RX));

  // R6: slave select neither placed nor flagged outside four-wire mode
  a_r6_sel_gated: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(spi_4wire_i))
      |-> (sel_hit == '0 && !sig_unplaced_o[SIG_SEL]));

  // R2: a signal occupies at most one pin
  a_r2_single_pin: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_hit));

  // R8: a signal goes unplaced only when every pin is used or skipped
  a_r8_unplaced_full: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (|sig_unplaced_o))
      |-> &(pin_used_o | $past(skip_q)));
endmodule

// File: tb/io_xbar_alloc_bench.sv
`timescale 1ns/1ps
module io_xbar_alloc_bench;
  localparam int NS = 17;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] sig_en = '0;
  logic          spi4 = 1'b0;
  logic          wr_en = 1'b0;
  logic [0:0]    wr_sel = '0;
  logic [7:0]    wr_data = '0;
  logic [NP*5-1:0] pin_func;
  logic [NP-1:0]   pin_used;
  logic [NS*4-1:0] sig_pin;
  logic [NS-1:0]   sig_unpl;

  int    errors = 0;
  int    checks = 0;
  bit    done   = 1'b0;
  string tag    = "R11";

  logic [15:0]     m_mask = '0;
  logic [NP*5-1:0] e_func;
  logic [NP-1:0]   e_used;
  logic [NS*4-1:0] e_pin;
  logic [NS-1:0]   e_unpl;

  always #2.5 clk = ~clk;

  io_xbar_alloc u_io_xbar_alloc (
    .clk            (clk),
    .rst            (rst),
    .sig_en_i       (sig_en),
    .spi_4wire_i    (spi4),
    .skip_wr_en_i   (wr_en),
    .skip_wr_sel_i  (wr_sel),
    .skip_wr_data_i (wr_data),
    .pin_func_o     (pin_func),
    .pin_used_o     (pin_used),
    .sig_pin_o      (sig_pin),
    .sig_unplaced_o (sig_unpl)
  );

  // Behavioural reference: a queue of free pins popped in priority order
  task automatic model(input logic [NS-1:0] en, input bit s4, input logic [15:0] mask);
    int free_q[$];
    e_func = '1;
    e_used = '0;
    e_pin  = '0;
    e_unpl = '0;
    if (en[0]) begin e_func[4*5 +: 5] = 5'd0; e_used[4] = 1'b1; e_pin[0 +: 4] = 4'd4; end
    if (en[1]) begin e_func[5*5 +: 5] = 5'd1; e_used[5] = 1'b1; e_pin[4 +: 4] = 4'd5; end
    for (int p = 0; p < NP; p++)
      if (!mask[p] && !(p == 4 && en[0]) && !(p == 5 && en[1])) free_q.push_back(p);
    for (int k = 2; k < NS; k++) begin
      if (en[k] && (k != 5 || s4)) begin
        if (free_q.size() == 0) e_unpl[k] = 1'b1;
        else begin
          int p = free_q.pop_front();
          e_func[p*5 +: 5] = 5'(k);
          e_used[p] = 1'b1;
          e_pin[k*4 +: 4] = 4'(p);
        end
      end
    end
  endtask

  task automatic cmp(input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One clock: predict from pre-edge inputs, then compare after the edge
  task automatic cycle();
    @(posedge clk);
    if (rst) begin
      e_func = '1; e_used = '0; e_pin = '0; e_unpl = '0;
      m_mask = '0;
    end else begin
      model(sig_en, spi4, m_mask);
      if (wr_en) begin
        if (wr_sel == 1'b0) m_mask[7:0] = wr_data;
        else                m_mask[15:8] = wr_data;
      end
    end
    @(negedge clk);
    cmp("pin_func", 128'(pin_func), 128'(e_func));
    cmp("pin_used", 128'(pin_used), 128'(e_used));
    cmp("sig_pin",  128'(sig_pin),  128'(e_pin));
    cmp("unplaced", 128'(sig_unpl), 128'(e_unpl));
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cycle();
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R11: reset state, skip write during reset ignored
    tag = "R11";
    sig_en = '1; spi4 = 1'b1;
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'hFF;
    repeat (3) cycle();
    wr_en = 1'b0;
    rst = 1'b0;
    // R1, R10: everything enabled, no skip; last signal runs out
    tag = "R1";
    repeat (2) cycle();
    // R6: slave select off in three-wire mode, on again
    tag = "R6";
    spi4 = 1'b0; cycle(); cycle();
    spi4 = 1'b1; cycle();
    // R7: disabled signals free their pins
    tag = "R7";
    for (int k = 0; k < NS; k++) begin
      sig_en = '1; sig_en[k] = 1'b0; cycle();
    end
    sig_en = 17'h0; cycle();
    sig_en = 17'h1_0004; cycle();
    // R4, R10: byte writes, two-edge latency
    tag = "R4";
    sig_en = '1;
    wr(1'b0, 8'h0F); cycle();
    wr(1'b1, 8'hA5); cycle();
    wr(1'b0, 8'h00); cycle();
    // R3: UART pins kept even when skipped
    tag = "R3";
    wr(1'b0, 8'h30); cycle();
    sig_en = 17'h0_0003; cycle();
    sig_en = 17'h1_FFFC; cycle();
    // R5: skipped pins avoided
    tag = "R5";
    sig_en = '1;
    wr(1'b1, 8'hFF); cycle();
    wr(1'b0, 8'h55); cycle();
    // R8: exhaustion
    tag = "R8";
    wr(1'b0, 8'hFF); cycle();
    sig_en = 17'h1_FFFC; cycle();
    wr(1'b1, 8'hFE); cycle();
    sig_en = 17'h0_0F00; cycle();
    wr(1'b0, 8'hF7); cycle();
    sig_en = 17'h1_0000; cycle();
    // R2: random traffic
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      sig_en = NS'($urandom);
      spi4   = 1'($urandom);
      wr_en  = ($urandom % 4) == 0;
      wr_sel = 1'($urandom);
      wr_data = ($urandom % 3 == 0) ? 8'($urandom | $urandom) : 8'($urandom & $urandom);
      cycle();
    end
    wr_en = 1'b0;
    // R11: reset again mid-run
    tag = "R11";
    rst = 1'b1; cycle(); cycle();
    rst = 1'b0; cycle();
    finish_run();
  end
endmodule